// File: doc/BRIEF.md
# Thermometer Function-Command Engine

This block is the command layer that sits behind the selection logic of a single-wire temperature slave. A link layer hands it bit-level events: a bus reset, write slots with a data bit, and read slots that sample the bit the block offers. After each bus reset, the block collects an 8-bit command, least significant bit first. It then either moves data into or out of a nine-byte scratchpad, or it reports progress on read slots.

The scratchpad holds the following fields. Bytes 0 and 1 carry the measured temperature. Bytes 2 and 3 carry the upper and lower alarm triggers. Bytes 4 and 5 are reserved. Byte 6 is the remaining count and byte 7 is the fixed per-degree count. Byte 8 is a CRC that is always current. A stub sensor port starts conversions and returns a result with a done strobe. An internal register model of the nonvolatile store keeps a saved copy of the triggers and signals busy while it copies or reloads. The block recomputes the alarm flag from every finished conversion.

Top module: `thermo_fc`

## Requirements
- R1: After rst_ni the scratchpad reads temperature 00AAh, upper trigger NV_TH_INIT, lower trigger NV_TL_INIT and remaining count CNT_REM_INIT, and alarm_o is 0.
- R2: Bytes 4 and 5 always read FFh, byte 7 always reads CNT_PER (10h), and byte 6 reads the last latched remain_i.
- R3: Command 44h pulses conv_start_o for one cycle. Read slots then return 0 until conv_done_i, and 1 after it. conv_done_i latches temp_i into bytes 1:0 and remain_i into byte 6.
- R4: Command 4Eh takes exactly 16 write bits, LSB first. The first 8 bits form byte 2 (upper trigger) and the next 8 form byte 3 (lower trigger). Both are updated together on the 16th bit.
- R5: Command BEh returns the scratchpad on read slots, starting at bit 0 of byte 0, through bit 7 of byte 8. Read slots after that return 1.
- R6: Byte 8 equals the CRC-8 of bytes 0 to 7, using polynomial x8+x5+x4+1, bit-reflected, zero initial value, with bits taken LSB first. It reflects the current contents on every read.
- R7: Command 48h saves bytes 2 and 3 to the store. Command B8h reloads them, and read slots return 0 while the store is busy and 1 once it is idle.
- R8: After command B4h, read slots return 0 when parasite_i is 1 and 1 when parasite_i is 0.
- R9: On each conv_done_i, alarm_o becomes 1 exactly when signed temp_i[8:1] is at most the lower trigger or above the upper trigger; otherwise it becomes 0.
- R10: A bus reset before the 16th bit of a 4Eh write leaves bytes 2 and 3 unchanged.
- R11: When the 16th 4Eh bit and conv_done_i fall in the same cycle, the alarm is judged against the newly written triggers.
- R12: After an unrecognised command, read slots return 1 and write slots change nothing until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset seen by link layer (one-cycle strobe) |
| wr_slot_i | input | 1 | Write slot strobe |
| wr_bit_i | input | 1 | Bit carried by the write slot |
| rd_slot_i | input | 1 | Read slot strobe; consumes rd_bit_o |
| rd_bit_o | output | 1 | Bit offered to the next read slot |
| parasite_i | input | 1 | 1 when the slave runs from bus power |
| conv_start_o | output | 1 | One-cycle conversion request to the sensor |
| conv_done_i | input | 1 | Sensor result strobe |
| temp_i | input | 16 | Sensor temperature, two's complement, 0.5 °C LSB |
| remain_i | input | 8 | Sensor remaining count |
| alarm_o | output | 1 | Alarm flag |

## Verification
The two functions that can coincide are a trigger write completing and a conversion result arriving. The bench lines up the 16th write slot of a 4Eh command with conv_done_i in the same cycle. It picks a temperature that raises the alarm under the new triggers but not under the old ones, so only the new triggers can explain the observed alarm_o. A second coincidence puts a bus reset on the cycle that would have carried the last write bit, and the bench checks through a later read that the triggers did not move.

// File: rtl/thermo_fc_pkg.sv
`timescale 1ns/1ps
package thermo_fc_pkg;
  localparam int SP_BYTES = 9;
  localparam logic [7:0] CMD_CONVERT = 8'h44;
  localparam logic [7:0] CMD_WRITE   = 8'h4E;
  localparam logic [7:0] CMD_READ    = 8'hBE;
  localparam logic [7:0] CMD_COPY    = 8'h48;
  localparam logic [7:0] CMD_RECALL  = 8'hB8;
  localparam logic [7:0] CMD_POWER   = 8'hB4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WRITE, ST_READ, ST_STATUS, ST_PWR
  } fc_state_e;
endpackage

// File: rtl/thermo_crc8.sv
`timescale 1ns/1ps
module thermo_crc8 #(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] data_i,
  output logic [7:0]          crc_o
);
  localparam int NBITS = NBYTES * 8;

  always_comb begin
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < NBITS; i++) begin
      fb = c[0] ^ data_i[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    crc_o = c;
  end
endmodule

// File: rtl/thermo_nv_store.sv
`timescale 1ns/1ps
module thermo_nv_store #(
  parameter int         LAT     = 20,
  parameter logic [7:0] TH_INIT = 8'h4B,
  parameter logic [7:0] TL_INIT = 8'hF6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       store_i,
  input  logic       load_i,
  input  logic [7:0] th_i,
  input  logic [7:0] tl_i,
  output logic [7:0] th_o,
  output logic [7:0] tl_o,
  output logic       busy_o,
  output logic       load_done_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          op_load_q, done_q;
  logic [7:0]    pend_th_q, pend_tl_q, th_q, tl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      op_load_q <= 1'b0;
      done_q    <= 1'b0;
      pend_th_q <= TH_INIT;
      pend_tl_q <= TL_INIT;
      th_q      <= TH_INIT;
      tl_q      <= TL_INIT;
    end else begin
      done_q <= 1'b0;
      if (cnt_q == '0) begin
        if (store_i) begin
          cnt_q     <= CW'(LAT);
          op_load_q <= 1'b0;
          pend_th_q <= th_i;
          pend_tl_q <= tl_i;
        end else if (load_i) begin
          cnt_q     <= CW'(LAT);
          op_load_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          if (op_load_q) done_q <= 1'b1;
          else begin
            th_q <= pend_th_q;
            tl_q <= pend_tl_q;
          end
        end
      end
    end
  end

  assign th_o        = th_q;
  assign tl_o        = tl_q;
  assign busy_o      = (cnt_q != '0) || done_q;
  assign load_done_o = done_q;
endmodule

// File: rtl/thermo_fc.sv
`timescale 1ns/1ps
module thermo_fc
  import thermo_fc_pkg::*;
#(
  parameter logic [15:0] TEMP_INIT    = 16'h00AA,
  parameter logic [7:0]  CNT_REM_INIT = 8'h0C,
  parameter logic [7:0]  CNT_PER      = 8'h10,
  parameter logic [7:0]  NV_TH_INIT   = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT   = 8'hF6,
  parameter int          NV_LAT       = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_reset_i,
  input  logic        wr_slot_i,
  input  logic        wr_bit_i,
  input  logic        rd_slot_i,
  output logic        rd_bit_o,
  input  logic        parasite_i,
  output logic        conv_start_o,
  input  logic        conv_done_i,
  input  logic [15:0] temp_i,
  input  logic [7:0]  remain_i,
  output logic        alarm_o
);
  localparam int SP_BITS   = SP_BYTES * 8;
  localparam int DATA_BITS = SP_BITS - 8;
  localparam int CW        = $clog2(SP_BITS + 1);

  fc_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   sh_q, temp_q;
  logic [7:0]    remain_q, th_q, tl_q, th_d, tl_d;
  logic          conv_busy_q, alarm_q, kind_nv_q, conv_start_q;

  logic [15:0]          wr_word;
  logic [7:0]           cmd;
  logic                 cmd_hit, wr_commit, alarm_d;
  logic                 nv_store, nv_load, nv_busy, nv_load_done;
  logic [7:0]           nv_th, nv_tl, crc;
  logic [DATA_BITS-1:0] sp;
  logic signed [7:0]    t8;

  assign wr_word   = {wr_bit_i, sh_q[15:1]};
  assign cmd       = wr_word[15:8];
  assign cmd_hit   = (state_q == ST_CMD) && wr_slot_i && !bus_reset_i && (cnt_q == CW'(7));
  assign wr_commit = (state_q == ST_WRITE) && wr_slot_i && !bus_reset_i && (cnt_q == CW'(15));
  assign nv_store  = cmd_hit && (cmd == CMD_COPY);
  assign nv_load   = cmd_hit && (cmd == CMD_RECALL);

  thermo_nv_store #(
    .LAT(NV_LAT), .TH_INIT(NV_TH_INIT), .TL_INIT(NV_TL_INIT)
  ) u_nv (
    .clk_i, .rst_ni,
    .store_i(nv_store), .load_i(nv_load),
    .th_i(th_q), .tl_i(tl_q),
    .th_o(nv_th), .tl_o(nv_tl),
    .busy_o(nv_busy), .load_done_o(nv_load_done)
  );

  assign sp = {CNT_PER, remain_q, 8'hFF, 8'hFF, tl_q, th_q, temp_q};

  thermo_crc8 #(.NBYTES(SP_BYTES - 1)) u_crc (.data_i(sp), .crc_o(crc));

  // write wins over a reload landing in the same cycle
  always_comb begin
    th_d = th_q;
    tl_d = tl_q;
    if (nv_load_done) begin
      th_d = nv_th;
      tl_d = nv_tl;
    end
    if (wr_commit) begin
      th_d = wr_word[7:0];
      tl_d = wr_word[15:8];
    end
  end

  // compare uses the triggers that take effect this cycle
  assign t8      = $signed(temp_i[8:1]);
  assign alarm_d = (t8 <= $signed(tl_d)) || (t8 > $signed(th_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      kind_nv_q <= 1'b0;
    end else if (bus_reset_i) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_CMD: if (wr_slot_i) begin
          sh_q  <= wr_word;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(7)) begin
            cnt_q <= '0;
            unique case (cmd)
              CMD_CONVERT: begin state_q <= ST_STATUS; kind_nv_q <= 1'b0; end
              CMD_COPY,
              CMD_RECALL:  begin state_q <= ST_STATUS; kind_nv_q <= 1'b1; end
              CMD_WRITE:   state_q <= ST_WRITE;
              CMD_READ:    state_q <= ST_READ;
              CMD_POWER:   state_q <= ST_PWR;
              default:     state_q <= ST_IDLE;
            endcase
          end
        end
        ST_WRITE: if (wr_slot_i) begin
          sh_q  <= wr_word;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(15)) state_q <= ST_IDLE;
        end
        ST_READ: if (rd_slot_i && cnt_q != CW'(SP_BITS)) cnt_q <= cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q       <= TEMP_INIT;
      remain_q     <= CNT_REM_INIT;
      th_q         <= NV_TH_INIT;
      tl_q         <= NV_TL_INIT;
      conv_busy_q  <= 1'b0;
      alarm_q      <= 1'b0;
      conv_start_q <= 1'b0;
    end else begin
      th_q         <= th_d;
      tl_q         <= tl_d;
      conv_start_q <= cmd_hit && (cmd == CMD_CONVERT) && !conv_busy_q;
      if (conv_done_i) begin
        temp_q      <= temp_i;
        remain_q    <= remain_i;
        alarm_q     <= alarm_d;
        conv_busy_q <= 1'b0;
      end
      if (cmd_hit && (cmd == CMD_CONVERT)) conv_busy_q <= 1'b1;
    end
  end

  always_comb begin
    rd_bit_o = 1'b1;
    unique case (state_q)
      ST_READ:
        if (cnt_q < CW'(DATA_BITS))    rd_bit_o = sp[cnt_q[5:0]];
        else if (cnt_q < CW'(SP_BITS)) rd_bit_o = crc[cnt_q[2:0]];
      ST_STATUS: rd_bit_o = kind_nv_q ? !nv_busy : !conv_busy_q;
      ST_PWR:    rd_bit_o = !parasite_i;
      default:   rd_bit_o = 1'b1;
    endcase
  end

  assign conv_start_o = conv_start_q;
  assign alarm_o      = alarm_q;
endmodule

// File: rtl/thermo_fc_chk.sv
`timescale 1ns/1ps
module thermo_fc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_reset_i,
  input logic        wr_slot_i,
  input logic        conv_start_o,
  input logic        conv_done_i,
  input logic        alarm_o,
  input logic [15:0] temp_q,
  input logic [7:0]  th_q,
  input logic [7:0]  tl_q,
  input logic        nv_load_done
);
  AST_START_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(wr_slot_i)); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R3
  AST_TEMP_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(temp_q) |-> $past(conv_done_i)); // R3
  AST_ALARM_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alarm_o) |-> $past(conv_done_i)); // R9
  AST_TRIG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({th_q, tl_q}) |-> (($past(wr_slot_i) && !$past(bus_reset_i)) || $past(nv_load_done))); // R10
endmodule

bind thermo_fc thermo_fc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i), .wr_slot_i(wr_slot_i),
  .conv_start_o(conv_start_o), .conv_done_i(conv_done_i), .alarm_o(alarm_o),
  .temp_q(temp_q), .th_q(th_q), .tl_q(tl_q), .nv_load_done(nv_load_done)
);

// File: tb/thermo_fc_tb.sv
`timescale 1ns/1ps
module thermo_fc_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 0, wr_slot = 0, wr_bit = 0, rd_slot = 0, parasite = 0, conv_done = 0;
  logic [15:0] temp = 0;
  logic [7:0]  remain = 0;
  logic rd_bit, conv_start, alarm;
  int nchk = 0, nfail = 0;

  logic [15:0] m_temp = 16'h00AA;
  logic [7:0]  m_rem = 8'h0C, m_th = 8'h4B, m_tl = 8'hF6;

  always #5 clk = ~clk;

  thermo_fc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .wr_slot_i(wr_slot),
    .wr_bit_i(wr_bit), .rd_slot_i(rd_slot), .rd_bit_o(rd_bit), .parasite_i(parasite),
    .conv_start_o(conv_start), .conv_done_i(conv_done), .temp_i(temp),
    .remain_i(remain), .alarm_o(alarm)
  );

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [63:0] d);
    logic [7:0] c = 0;
    for (int i = 0; i < 64; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c ^= 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [71:0] exp_sp();
    logic [63:0] d = {8'h10, m_rem, 8'hFF, 8'hFF, m_tl, m_th, m_temp};
    return {crc8(d), d};
  endfunction

  task automatic busrst();
    @(negedge clk) bus_reset = 1;
    @(negedge clk) bus_reset = 0;
  endtask
  task automatic wbit(input logic b);
    @(negedge clk) begin wr_slot = 1; wr_bit = b; end
    @(negedge clk) wr_slot = 0;
  endtask
  task automatic wbyte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) wbit(b[i]);
  endtask
  task automatic rbit(output logic b);
    @(negedge clk) begin b = rd_bit; rd_slot = 1; end
    @(negedge clk) rd_slot = 0;
  endtask
  task automatic read_sp(output logic [71:0] v);
    busrst(); wbyte(8'hBE);
    for (int i = 0; i < 72; i++) begin
      logic b; rbit(b); v[i] = b;
    end
  endtask
  task automatic write_trig(input logic [7:0] th, input logic [7:0] tl);
    busrst(); wbyte(8'h4E); wbyte(th); wbyte(tl);
    m_th = th; m_tl = tl;
  endtask
  task automatic check_sp(input string req);
    logic [71:0] v;
    read_sp(v);
    chk(v === exp_sp(), req, v, exp_sp());
  endtask
  function automatic logic exp_alarm(input logic [15:0] t);
    int t8 = $signed(t[8:1]);
    return (t8 <= $signed(m_tl)) || (t8 > $signed(m_th));
  endfunction
  task automatic convert(input logic [15:0] t, input logic [7:0] r, input bit chk_status);
    logic b;
    busrst(); wbyte(8'h44);
    if (chk_status) begin
      rbit(b); chk(b == 0, "R3 busy", b, 0);
    end
    @(negedge clk) begin conv_done = 1; temp = t; remain = r; end
    @(negedge clk) conv_done = 0;
    m_temp = t; m_rem = r;
    if (chk_status) begin
      rbit(b); chk(b == 1, "R3 done", b, 1);
    end
  endtask

  initial begin
    #1_500_000;
    nchk++; nfail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [71:0] v;
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(alarm == 0, "R1 alarm", alarm, 0);
    check_sp("R1 R2 R6 reset map");

    // R3: convert handshake, start pulse
    busrst(); wbyte(8'h44);
    chk(conv_start == 1, "R3 start", conv_start, 1);
    @(negedge clk) chk(conv_start == 0, "R3 pulse", conv_start, 0);
    rbit(b); chk(b == 0, "R3 busy", b, 0);
    @(negedge clk) begin conv_done = 1; temp = 16'hFFCE; remain = 8'h07; end
    @(negedge clk) conv_done = 0;
    m_temp = 16'hFFCE; m_rem = 8'h07;
    rbit(b); chk(b == 1, "R3 done", b, 1);
    check_sp("R2 R3 R6 latched result");

    // R4 R5 R6: trigger write sweep with full readback
    for (int k = 0; k < 24; k++) begin
      write_trig(8'(k * 37 + 3), 8'(k * 91 + 200));
      check_sp("R4 R5 R6 write/read");
    end
    // R5: slots past byte 8 return 1
    for (int i = 0; i < 4; i++) begin
      rbit(b); chk(b == 1, "R5 tail", b, 1);
    end

    // R9: sweep every compared temperature value under two trigger pairs
    write_trig(8'sd20, -8'sd10);
    for (int t = -128; t < 128; t++) begin
      logic [15:0] tv = {{7{t[7]}}, 8'(t), t[0] ^ 1'b1};
      convert(tv, 8'(t), t == 0);
      chk(alarm == exp_alarm(tv), "R9 alarm sweep A", alarm, exp_alarm(tv));
    end
    write_trig(-8'sd5, -8'sd5);
    for (int t = -128; t < 128; t += 3) begin
      logic [15:0] tv = {{7{t[7]}}, 8'(t), 1'b1};
      convert(tv, 8'h0C, 1'b0);
      chk(alarm == exp_alarm(tv), "R9 alarm sweep B", alarm, exp_alarm(tv));
    end
    check_sp("R6 after sweep");

    // R7: copy, overwrite, recall with status
    write_trig(8'h3C, 8'h11);
    busrst(); wbyte(8'h48);
    repeat (30) @(negedge clk);
    write_trig(8'h99, 8'h88);
    busrst(); wbyte(8'hB8);
    rbit(b); chk(b == 0, "R7 recall busy", b, 0);
    begin
      int n = 0;
      do begin rbit(b); n++; end while (b == 0 && n < 100);
      chk(b == 1, "R7 recall done", b, 1);
    end
    m_th = 8'h3C; m_tl = 8'h11;
    check_sp("R7 recalled");

    // R8: power query
    parasite = 1; busrst(); wbyte(8'hB4);
    rbit(b); chk(b == 0, "R8 parasite", b, 0);
    parasite = 0; busrst(); wbyte(8'hB4);
    rbit(b); chk(b == 1, "R8 external", b, 1);

    // R10: aborted writes at several bit counts
    for (int cut = 1; cut < 16; cut += 7) begin
      busrst(); wbyte(8'h4E);
      for (int i = 0; i < cut; i++) wbit(1'b0);
      busrst();
      check_sp("R10 abort");
    end
    // R10: bus reset on the cycle that would carry bit 16
    busrst(); wbyte(8'h4E);
    for (int i = 0; i < 15; i++) wbit(1'b0);
    @(negedge clk) begin wr_slot = 1; wr_bit = 0; bus_reset = 1; end
    @(negedge clk) begin wr_slot = 0; bus_reset = 0; end
    check_sp("R10 reset on last bit");

    // R11: last write bit and conversion result in the same cycle
    write_trig(8'sd100, -8'sd100);
    convert(16'h0032, 8'h05, 1'b0);
    chk(alarm == 0, "R11 precondition", alarm, 0);
    busrst(); wbyte(8'h4E); wbyte(8'sd10);
    for (int i = 0; i < 7; i++) wbit(1'b0);
    @(negedge clk) begin wr_slot = 1; wr_bit = 0; conv_done = 1; temp = 16'h0032; remain = 8'h06; end
    @(negedge clk) begin wr_slot = 0; conv_done = 0; end
    m_th = 8'sd10; m_tl = 8'h00; m_temp = 16'h0032; m_rem = 8'h06;
    chk(alarm == 1, "R11 new triggers", alarm, 1);
    check_sp("R11 scratchpad");

    // R12: unknown command
    busrst(); wbyte(8'h12); wbyte(8'h00); wbyte(8'h00);
    rbit(b); chk(b == 1, "R12 read", b, 1);
    check_sp("R12 unchanged");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule